// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is the configuration register file of a local-bus disk interface controller. The host reaches it through two byte ports. A byte written to the index port (bus offset 0) selects one internal register. A read or write at the data port (bus offset 4) then reaches the selected register. The file holds a configuration/revision register, a control register, a command-block timing register, per-drive address-setup and read/write pulse timing registers, a burst-size register and a scratch register. Software uses the scratch register to probe for presence.

The stored fields are decoded continuously and sent to the drive timing logic: per-drive prefetch disables, the secondary channel enable, the fast device-select selection, and per-drive setup, active and recovery counts. The two secondary drives share one setup/pulse register pair, so both always see the same timing. Their prefetch disables sit in the shared setup register. The primary drives' prefetch disables sit in the control register.

Top module: `cfg_index_port`

## Requirements
- R1: A write at bus offset 0 loads the index register on the next clock edge. A read at offset 0 returns the current index.
- R2: A write at bus offset 4 updates the register selected by the index on the next clock edge. Indices 0x51 to 0x59 are fully writable. A read at offset 4 returns the selected register.
- R3: Register 0x50 reads revision parameter REV_ID in bits 1:0 and parameter ALT_BASE in bit 5. Writes never change these bits. Bits 7:6 and 4:2 are writable.
- R4: With an index outside 0x50 to 0x5B, a data read returns 0xFF and a data write changes no register.
- R5: Prefetch-disable outputs, one per drive: drive 0 = 0x51 bit 6, drive 1 = 0x51 bit 7, drive 2 = 0x57 bit 2, drive 3 = 0x57 bit 3.
- R6: The secondary channel enable output follows 0x51 bit 3.
- R7: The fast device-select output is 1 exactly when 0x51 bits 0, 1, 2 and 5 are all set (mask 0x27).
- R8: For each drive, the setup code (2 bits) is bits 7:6 of its setup register, and the active and recovery counts are the high and low nibbles of its pulse register. Drive 0 uses 0x53/0x54. Drive 1 uses 0x55/0x56. Drives 2 and 3 both use 0x57/0x58. Outputs pack drive d at bits [2d+1:2d] and [4d+3:4d].
- R9: After reset the index is 0x00, every register reads 0x00 except 0x50, which reads its read-only fields, and all decoded outputs are 0.
- R10: Register 0x5B returns exactly the last byte written to it, including 0xBD and 0x00.
- R11: Bus offsets other than 0 and 4 read 0xFF, and writes to them have no effect.
- R12: Index 0x5A is reserved. It reads 0x00 and ignores writes.
- R13: Register 0x52 drives the command timing output and register 0x59 drives the burst output (0x40 selects the default 512-byte burst).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 3 | Byte offset from the port base |
| bus_wr_i | input | 1 | Write strobe for the current cycle |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i (combinational) |
| rev_valid_o | output | 1 | Revision field is nonzero |
| alt_base_o | output | 1 | Alternate base address in use |
| sec_en_o | output | 1 | Secondary channel enabled |
| fast_devsel_o | output | 1 | Fast device-select host timing |
| prefetch_dis_o | output | 4 | Prefetch disable per drive |
| cmd_timing_o | output | 8 | Command block timing byte |
| setup_o | output | 8 | Setup codes, 2 bits per drive |
| active_o | output | 16 | Active counts, 4 bits per drive |
| recov_o | output | 16 | Recovery counts, 4 bits per drive |
| burst_o | output | 8 | Burst-size byte |

## Verification
The hardest condition to reach is a state where the shared secondary register pair carries timing and prefetch bits at the same time as the primary drives' own registers hold different values. Only then can a wrong per-drive routing show up on the packed outputs. The stimulus loads distinct, non-symmetric patterns into 0x53, 0x54, 0x57 and 0x58 through index/data pairs, then checks all four drive slices at once. It also rewrites 0x57 so that the drive 2 and drive 3 prefetch bits swap, which exposes any crossed bit.

// File: rtl/cfg_index_pkg.sv
package cfg_index_pkg;
  localparam int DW       = 8;
  localparam int NREG     = 12;
  localparam int SELW     = $clog2(NREG);
  localparam int NDRV     = 4;
  localparam logic [DW-1:0] IDX_FIRST = 8'h50;
  localparam logic [DW-1:0] IDX_LAST  = IDX_FIRST + NREG[DW-1:0] - 8'd1;

  localparam int R_CFG   = 0;
  localparam int R_CTRL  = 1;
  localparam int R_CMD   = 2;
  localparam int R_SET0  = 3;
  localparam int R_SET23 = 7;
  localparam int R_DRW23 = 8;
  localparam int R_BURST = 9;
  localparam int R_RSVD  = 10;
  localparam int R_SCR   = 11;

  localparam logic [DW-1:0] CFG_WMASK  = 8'hDC;
  localparam logic [DW-1:0] FAST_MASK  = 8'h27;

  function automatic logic [DW-1:0] wmask(input int i);
    if (i == R_CFG)       return CFG_WMASK;
    else if (i == R_RSVD) return '0;
    else                  return '1;
  endfunction

  function automatic int setup_reg(input int d);
    return (d < 2) ? (R_SET0 + 2 * d) : R_SET23;
  endfunction

  function automatic int pf_bit(input int d);
    return (d < 2) ? (6 + d) : d;
  endfunction
endpackage

// File: rtl/cfg_index_decode.sv
module cfg_index_decode
  import cfg_index_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int IDX_OFS  = 0,
  parameter int DATA_OFS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     index_o,
  output logic              idx_hit_o,
  output logic              data_hit_o,
  output logic              in_range_o,
  output logic [SELW-1:0]   sel_o,
  output logic              data_wr_o
);
  logic [DW-1:0] index_q;
  logic [DW-1:0] offs;

  assign idx_hit_o  = (bus_addr_i == ADDR_W'(IDX_OFS));
  assign data_hit_o = (bus_addr_i == ADDR_W'(DATA_OFS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     index_q <= '0;
    else if (bus_wr_i && idx_hit_o)  index_q <= bus_wdata_i;
  end

  assign offs       = index_q - IDX_FIRST;
  assign in_range_o = (index_q >= IDX_FIRST) && (index_q <= IDX_LAST);
  assign sel_o      = offs[SELW-1:0];
  assign data_wr_o  = bus_wr_i && data_hit_o && in_range_o;
  assign index_o    = index_q;

  a_r1_index_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == ADDR_W'(IDX_OFS)) |=> index_o == $past(bus_wdata_i));
  a_r11_other_ofs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i != ADDR_W'(IDX_OFS)) |=> $stable(index_o));
endmodule

// File: rtl/cfg_index_bank.sv
module cfg_index_bank
  import cfg_index_pkg::*;
#(
  parameter logic [1:0] REV_ID   = 2'd2,
  parameter logic       ALT_BASE = 1'b0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [SELW-1:0]          sel_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [NREG-1:0][DW-1:0]  regs_o
);
  localparam logic [DW-1:0] CFG_RST = {2'b00, ALT_BASE, 3'b000, REV_ID};

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] WM  = wmask(i);
    localparam logic [DW-1:0] RST = (i == R_CFG) ? CFG_RST : '0;
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            q <= RST;
      else if (wr_i && sel_i == SELW'(i))     q <= (q & ~WM) | (wdata_i & WM);
    end
    assign regs_o[i] = q;
  end

  a_r3_cfg_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SELW'(R_CFG)) |=> (regs_o[R_CFG] & ~CFG_WMASK) == $past(regs_o[R_CFG] & ~CFG_WMASK));
  a_r10_scratch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == SELW'(R_SCR)) |=> regs_o[R_SCR] == $past(wdata_i));
  a_r12_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(regs_o[R_RSVD]));
endmodule

// File: rtl/cfg_index_fields.sv
module cfg_index_fields
  import cfg_index_pkg::*;
(
  input  logic [NREG-1:0][DW-1:0] regs_i,
  output logic                    rev_valid_o,
  output logic                    alt_base_o,
  output logic                    sec_en_o,
  output logic                    fast_devsel_o,
  output logic [NDRV-1:0]         prefetch_dis_o,
  output logic [DW-1:0]           cmd_timing_o,
  output logic [2*NDRV-1:0]       setup_o,
  output logic [4*NDRV-1:0]       active_o,
  output logic [4*NDRV-1:0]       recov_o,
  output logic [DW-1:0]           burst_o
);
  assign rev_valid_o   = |regs_i[R_CFG][1:0];
  assign alt_base_o    = regs_i[R_CFG][5];
  assign sec_en_o      = regs_i[R_CTRL][3];
  assign fast_devsel_o = (regs_i[R_CTRL] & FAST_MASK) == FAST_MASK;
  assign cmd_timing_o  = regs_i[R_CMD];
  assign burst_o       = regs_i[R_BURST];

  for (genvar d = 0; d < NDRV; d++) begin : g_drv
    localparam int SR = setup_reg(d);
    localparam int PR = (d < 2) ? R_CTRL : R_SET23;
    assign setup_o[2*d +: 2]  = regs_i[SR][7:6];
    assign active_o[4*d +: 4] = regs_i[SR+1][7:4];
    assign recov_o[4*d +: 4]  = regs_i[SR+1][3:0];
    assign prefetch_dis_o[d]  = regs_i[PR][pf_bit(d)];
  end
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfg_index_pkg::*;
#(
  parameter logic [1:0] REV_ID   = 2'd2,
  parameter logic       ALT_BASE = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  bus_addr_i,
  input  logic        bus_wr_i,
  input  logic [7:0]  bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  output logic        rev_valid_o,
  output logic        alt_base_o,
  output logic        sec_en_o,
  output logic        fast_devsel_o,
  output logic [3:0]  prefetch_dis_o,
  output logic [7:0]  cmd_timing_o,
  output logic [7:0]  setup_o,
  output logic [15:0] active_o,
  output logic [15:0] recov_o,
  output logic [7:0]  burst_o
);
  logic [DW-1:0]           index;
  logic                    idx_hit, data_hit, in_range, data_wr;
  logic [SELW-1:0]         sel;
  logic [NREG-1:0][DW-1:0] regs;

  cfg_index_decode #(.ADDR_W(3), .IDX_OFS(0), .DATA_OFS(4)) u_dec (
    .clk_i, .rst_ni, .bus_addr_i, .bus_wr_i, .bus_wdata_i,
    .index_o(index), .idx_hit_o(idx_hit), .data_hit_o(data_hit),
    .in_range_o(in_range), .sel_o(sel), .data_wr_o(data_wr)
  );

  cfg_index_bank #(.REV_ID(REV_ID), .ALT_BASE(ALT_BASE)) u_bank (
    .clk_i, .rst_ni, .wr_i(data_wr), .sel_i(sel), .wdata_i(bus_wdata_i), .regs_o(regs)
  );

  cfg_index_fields u_fld (
    .regs_i(regs), .rev_valid_o, .alt_base_o, .sec_en_o, .fast_devsel_o,
    .prefetch_dis_o, .cmd_timing_o, .setup_o, .active_o, .recov_o, .burst_o
  );

  always_comb begin
    if (idx_hit)                   bus_rdata_o = index;
    else if (data_hit && in_range) bus_rdata_o = regs[sel];
    else                           bus_rdata_o = 8'hFF;
  end

  a_r4_oor_nowrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && data_hit && !in_range) |=> $stable(regs));
  a_r8_shared_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_o[5:4] == setup_o[7:6] && active_o[11:8] == active_o[15:12] && recov_o[11:8] == recov_o[15:12]);
endmodule

// File: tb/sim_cfg_index_port.sv
module sim_cfg_index_port;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  addr = 0;
  logic        wr = 0;
  logic [7:0]  wdata = 0, rdata;
  logic        rev_valid, alt_base, sec_en, fast;
  logic [3:0]  pf;
  logic [7:0]  cmdt, setup, burst;
  logic [15:0] act, rec;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cfg_index_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .rev_valid_o(rev_valid), .alt_base_o(alt_base), .sec_en_o(sec_en),
    .fast_devsel_o(fast), .prefetch_dis_o(pf), .cmd_timing_o(cmdt), .setup_o(setup),
    .active_o(act), .recov_o(rec), .burst_o(burst)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0; addr = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    bus_wr(3'd0, idx); bus_wr(3'd4, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    bus_wr(3'd0, idx); bus_rd(3'd4, d);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    bus_rd(3'd0, v); chk("R9 index", v, 8'h00);
    reg_rd(8'h50, v); chk("R9 cfg", v, 8'h02);
    reg_rd(8'h51, v); chk("R9 ctrl", v, 8'h00);
    reg_rd(8'h5B, v); chk("R9 scratch", v, 8'h00);
    chk("R9 outs", {sec_en, fast, pf, setup, act, rec, burst, cmdt}, '0);
    chk("R3 rev_valid", {rev_valid, alt_base}, 2'b10);
  endtask

  task automatic t_index_rw;
    logic [7:0] v;
    bus_wr(3'd0, 8'h37); bus_rd(3'd0, v); chk("R1 index", v, 8'h37);
    for (int i = 8'h51; i <= 8'h59; i++) reg_wr(i[7:0], 8'hA0 ^ i[7:0]);
    for (int i = 8'h51; i <= 8'h59; i++) begin
      reg_rd(i[7:0], v); chk("R2 rw", v, 8'hA0 ^ i[7:0]);
    end
    for (int i = 8'h51; i <= 8'h59; i++) reg_wr(i[7:0], 8'h00);
  endtask

  task automatic t_cfg_ro;
    logic [7:0] v;
    reg_wr(8'h50, 8'hFF); reg_rd(8'h50, v); chk("R3 cfg ff", v, 8'hDE);
    reg_wr(8'h50, 8'h00); reg_rd(8'h50, v); chk("R3 cfg 00", v, 8'h02);
  endtask

  task automatic t_scratch;
    logic [7:0] v;
    reg_wr(8'h5B, 8'hBD); reg_rd(8'h5B, v); chk("R10 bd", v, 8'hBD);
    reg_wr(8'h5B, 8'h00); reg_rd(8'h5B, v); chk("R10 00", v, 8'h00);
    reg_wr(8'h5A, 8'hFF); reg_rd(8'h5A, v); chk("R12 rsvd", v, 8'h00);
  endtask

  task automatic t_out_of_range;
    logic [7:0] v;
    reg_wr(8'h5B, 8'h5A);
    reg_wr(8'h4F, 8'h11); reg_rd(8'h4F, v); chk("R4 rd 4f", v, 8'hFF);
    reg_wr(8'h5C, 8'h22); reg_rd(8'h5C, v); chk("R4 rd 5c", v, 8'hFF);
    reg_wr(8'h00, 8'h33);
    reg_rd(8'h5B, v); chk("R4 scratch kept", v, 8'h5A);
    reg_rd(8'h50, v); chk("R4 cfg kept", v, 8'h02);
    bus_wr(3'd0, 8'h5B); bus_wr(3'd2, 8'h51); bus_wr(3'd5, 8'h77);
    bus_rd(3'd0, v); chk("R11 index kept", v, 8'h5B);
    bus_rd(3'd4, v); chk("R11 data kept", v, 8'h5A);
    bus_rd(3'd2, v); chk("R11 rd ofs2", v, 8'hFF);
  endtask

  task automatic t_ctrl;
    reg_wr(8'h51, 8'h27); #1;
    chk("R7 fast on", fast, 1'b1); chk("R6 sec off", sec_en, 1'b0); chk("R5 pf", pf, 4'b0000);
    reg_wr(8'h51, 8'h26); #1; chk("R7 fast off", fast, 1'b0);
    reg_wr(8'h51, 8'hC8); #1;
    chk("R6 sec on", sec_en, 1'b1); chk("R5 pf01", pf, 4'b0011); chk("R7 fast off2", fast, 1'b0);
    reg_wr(8'h51, 8'h40); #1; chk("R5 pf0", pf, 4'b0001);
  endtask

  task automatic t_timing;
    reg_wr(8'h51, 8'h00);
    reg_wr(8'h53, 8'h80); reg_wr(8'h54, 8'h3A);
    reg_wr(8'h55, 8'h40); reg_wr(8'h56, 8'h71);
    reg_wr(8'h57, 8'hC4); reg_wr(8'h58, 8'h5C); #1;
    chk("R8 setup", setup, 8'hF6);
    chk("R8 active", act, 16'h5573);
    chk("R8 recov", rec, 16'hCC1A);
    chk("R5 pf2", pf, 4'b0100);
    reg_wr(8'h57, 8'h08); #1;
    chk("R5 pf3", pf, 4'b1000); chk("R8 setup2", setup, 8'h06);
    reg_wr(8'h52, 8'h00); reg_wr(8'h59, 8'h40); reg_wr(8'h52, 8'h9E); #1;
    chk("R13 burst", burst, 8'h40); chk("R13 cmd", cmdt, 8'h9E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_index_rw();
    t_cfg_ro();
    t_scratch();
    t_out_of_range();
    t_ctrl();
    t_timing();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); fails++; checks++; $display("FAIL watchdog expired"); end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule